// File: doc/BRIEF.md
# Sector Protect Command Sequencer

This controller runs a write-driven procedure that marks flash sectors as protected. The procedure is open only while a flag reports a raised voltage on the reset pin. The host first sends a setup write of 60h. After that it can ask for a protect pulse on one sector, or select a sector for a verify read. The sector number is taken from address bits 18..12, so 128 sectors can be addressed. The protect pulse is a request to the array that lasts for a parameterised number of cycles. A busy flag is high for the same cycles.

Protection state is held in a 128-bit register, one bit per sector. A verify read returns the bit of the selected sector on data bit 0. If that bit reads 0, the host may send the protect command again. When the voltage flag drops, the mode ends and any pulse in progress is abandoned.

Top module: `sps_top`

## Requirements
- R1: After reset, `busy`, `pulse_req`, `rd_valid` and `rd_data` are 0 and every sector reads back as unprotected.
- R2: While `hv_present` is 0, every write is ignored: no pulse starts and no protection bit changes.
- R3: With `hv_present` at 1 and the sequencer idle, a write of 60h at any address is only the setup step. It starts no pulse.
- R4: Once set up, a write of 60h with address bits 6, 1, 0 equal to 0, 1, 0 starts a pulse on sector `wr_addr[18:12]`. `busy` and `pulse_req` are 1 for exactly PULSE_CYCLES cycles, starting the cycle after the write, and `pulse_sector` shows that sector throughout.
- R5: A pulse that completes sets the sector's protection bit. The sequencer then stays set up for further commands without a new setup write.
- R6: A write of 60h or 40h whose bits 6, 1, 0 are not 0, 1, 0 is ignored while set up. It starts no pulse and does not change the verify selection.
- R7: While set up, a write of 40h with the 0, 1, 0 pattern selects a sector for verify. A read (`rd_en`) gives `rd_valid` one cycle later. `rd_data[0]` is that sector's protection bit and `rd_data[7:1]` is 0.
- R8: A protect command may be sent again for a sector that is already protected, or for any other sector. Each command runs a full pulse and leaves the sector protected.
- R9: Writes that arrive while `busy` is 1 are ignored. The pulse length is not extended and no other sector becomes protected.
- R10: If `hv_present` falls while `busy` is 1, `busy` is 0 on the next cycle and the sector is not protected. This holds even when the fall lands on the pulse's final cycle.
- R11: When `hv_present` falls, the mode ends. The verify selection is cleared, so reads return 0. After the flag rises again, a new setup write is required.
- R12: A read is answered from the protection state in the cycle of `rd_en`. A read in the same cycle that a pulse completes on the selected sector returns the earlier value, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hv_present | input | 1 | Raised voltage detected on the reset pin |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data (command byte) |
| rd_en | input | 1 | Verify read strobe |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 8 | Read data: bit 0 is the protection status, other bits are 0 |
| busy | output | 1 | Protect pulse in progress |
| pulse_req | output | 1 | Protect pulse request to the array |
| pulse_sector | output | 7 | Sector receiving the pulse |

## Verification
Two events can fall in the same cycle: a pulse completing, and either the voltage flag falling or a verify read of the same sector. The bench provokes each collision by changing `hv_present` or raising `rd_en` exactly on the pulse's last busy cycle. It judges the outcome at the ports. A fall on that cycle must leave the sector unprotected, which a later verify shows. A read on that cycle must return 0, and a read one cycle later must return 1.

// File: rtl/sps_pkg.sv
package sps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PULSE = 2'd2
    } sps_state_e;

    localparam logic [7:0] OP_PROTECT = 8'h60;
    localparam logic [7:0] OP_VERIFY  = 8'h40;
    localparam logic [2:0] LOW_PATTERN = 3'b010;
endpackage

// File: rtl/sps_cmd_decode.sv
module sps_cmd_decode #(
    parameter int ADDR_W  = 19,
    parameter int SEC_LSB = 12,
    parameter int SEC_W   = 7
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              is_setup,
    output logic              is_protect,
    output logic              is_verify,
    output logic [SEC_W-1:0]  sector
);
    import sps_pkg::*;

    logic pat_ok;

    always_comb begin
        pat_ok     = ({wr_addr[6], wr_addr[1], wr_addr[0]} == LOW_PATTERN);
        is_setup   = (wr_data == OP_PROTECT);
        is_protect = (wr_data == OP_PROTECT) && pat_ok;
        is_verify  = (wr_data == OP_VERIFY) && pat_ok;
        sector     = wr_addr[SEC_LSB +: SEC_W];
    end
endmodule

// File: rtl/sps_pulse_timer.sv
module sps_pulse_timer #(
    parameter int PULSE_CYCLES = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic active,
    output logic last
);
    localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (abort) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = LOAD;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign active = tmr_q.run;
    assign last   = tmr_q.run && (tmr_q.cnt == '0);
endmodule

// File: rtl/sps_prot_bank.sv
module sps_prot_bank #(
    parameter int SEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [SEC_W-1:0] set_idx,
    input  logic [SEC_W-1:0] rd_idx,
    output logic             rd_bit
);
    localparam int N_SEC = 1 << SEC_W;

    logic [N_SEC-1:0] prot_d, prot_q;

    for (genvar i = 0; i < N_SEC; i++) begin : g_bit
        always_comb begin
            prot_d[i] = prot_q[i] | (set_en && (set_idx == SEC_W'(i)));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prot_q[i] <= 1'b0;
            end else begin
                prot_q[i] <= prot_d[i];
            end
        end
    end

    assign rd_bit = prot_q[rd_idx];
endmodule

// File: rtl/sps_top.sv
module sps_top #(
    parameter int ADDR_W       = 19,
    parameter int SEC_LSB      = 12,
    parameter int SEC_W        = 7,
    parameter int PULSE_CYCLES = 30000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_present,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              pulse_req,
    output logic [SEC_W-1:0]  pulse_sector
);
    import sps_pkg::*;

    typedef struct packed {
        sps_state_e       state;
        logic [SEC_W-1:0] psel;
        logic             vpend;
        logic [SEC_W-1:0] vsel;
        logic             rvalid;
        logic             rbit;
    } seq_t;

    seq_t s_d, s_q;

    logic             dec_setup, dec_protect, dec_verify;
    logic [SEC_W-1:0] dec_sector;
    logic             tmr_start, tmr_abort, tmr_active, tmr_last;
    logic             bank_set, bank_bit;

    sps_cmd_decode #(
        .ADDR_W (ADDR_W),
        .SEC_LSB(SEC_LSB),
        .SEC_W  (SEC_W)
    ) u_dec (
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .is_setup  (dec_setup),
        .is_protect(dec_protect),
        .is_verify (dec_verify),
        .sector    (dec_sector)
    );

    sps_pulse_timer #(
        .PULSE_CYCLES(PULSE_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .abort (tmr_abort),
        .active(tmr_active),
        .last  (tmr_last)
    );

    sps_prot_bank #(
        .SEC_W(SEC_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (bank_set),
        .set_idx(s_q.psel),
        .rd_idx (s_q.vsel),
        .rd_bit (bank_bit)
    );

    always_comb begin
        s_d       = s_q;
        tmr_start = 1'b0;
        tmr_abort = 1'b0;
        bank_set  = 1'b0;

        // Read path is answered from the state of this cycle.
        s_d.rvalid = rd_en;
        s_d.rbit   = rd_en && s_q.vpend && bank_bit;

        if (!hv_present) begin
            s_d.state = ST_IDLE;
            s_d.vpend = 1'b0;
            tmr_abort = 1'b1;
        end else begin
            unique case (s_q.state)
                ST_IDLE: begin
                    if (wr_en && dec_setup) begin
                        s_d.state = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (wr_en && dec_protect) begin
                        s_d.state = ST_PULSE;
                        s_d.psel  = dec_sector;
                        tmr_start = 1'b1;
                    end else if (wr_en && dec_verify) begin
                        s_d.vpend = 1'b1;
                        s_d.vsel  = dec_sector;
                    end
                end
                ST_PULSE: begin
                    if (tmr_last) begin
                        bank_set  = 1'b1;
                        s_d.state = ST_ARMED;
                    end
                end
                default: begin
                    s_d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, psel: '0, vpend: 1'b0, vsel: '0,
                     rvalid: 1'b0, rbit: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy         = (s_q.state == ST_PULSE) && tmr_active;
    assign pulse_req    = busy;
    assign pulse_sector = s_q.psel;
    assign rd_valid     = s_q.rvalid;
    assign rd_data      = {7'b0, s_q.rbit};
endmodule

// File: rtl/sps_chk.sv
module sps_chk #(
    parameter int ADDR_W = 19,
    parameter int SEC_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hv_present,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [7:0]        rd_data,
    input logic              busy,
    input logic              pulse_req,
    input logic [SEC_W-1:0]  pulse_sector
);
    p_abort_on_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !hv_present) |=> !busy);

    p_no_start_when_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_present |=> !busy);

    p_start_needs_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && wr_data == 8'h60 && hv_present));

    p_sector_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> (!busy || $stable(pulse_sector)));

    p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_upper_bits_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[7:1] == 7'b0));

    p_req_tracks_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_req) |-> busy);
endmodule

bind sps_top sps_chk #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_chk (.*);

// File: tb/sps_top_tb.sv
module sps_top_tb;
    localparam int P = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hv_present = 1'b0;
    logic        wr_en = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        busy;
    logic        pulse_req;
    logic [6:0]  pulse_sector;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];

    always #2.5 clk = ~clk;

    sps_top #(.PULSE_CYCLES(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .hv_present(hv_present),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .pulse_req(pulse_req), .pulse_sector(pulse_sector)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] mk_addr(input logic [6:0] sec, input logic [2:0] pat);
        logic [18:0] a = '0;
        a[18:12] = sec;
        a[6] = pat[2];
        a[1] = pat[1];
        a[0] = pat[0];
        return a;
    endfunction

    // Monitor: pops expected bytes as read results appear.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(rd_data, 8'hxx, "R7 unexpected rd_valid");
            end else begin
                check(rd_data, exp_q.pop_front(), req_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [6:0] sec, input logic [2:0] pat, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = mk_addr(sec, pat); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic expbit, input string req);
        rd_en = 1'b1;
        exp_q.push_back({7'b0, expbit});
        req_q.push_back(req);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    // Follows a pulse that started on the write just issued.
    task automatic follow_pulse(input logic [6:0] sec, input int drop_at, input int wr_at,
                                input int rd_at, input logic rd_exp);
        for (int k = 0; k < P; k++) begin
            check(busy, 1, "R4 busy during pulse");
            check(pulse_req, 1, "R4 pulse_req during pulse");
            check(pulse_sector, sec, "R4 pulse_sector");
            if (k == drop_at) hv_present = 1'b0;
            if (k == wr_at) begin
                wr_en = 1'b1; wr_addr = mk_addr(7'd11, 3'b010); wr_data = 8'h60;
            end
            if (k == rd_at) begin
                rd_en = 1'b1;
                exp_q.push_back({7'b0, rd_exp});
                req_q.push_back("R12 read at completion");
            end
            @(negedge clk);
            wr_en = 1'b0;
            rd_en = 1'b0;
            if (k == drop_at) begin
                check(busy, 0, "R10 abort clears busy");
                return;
            end
        end
        check(busy, 0, "R4 pulse length");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy, 0, "R1 busy");
        check(pulse_req, 0, "R1 pulse_req");
        check(rd_valid, 0, "R1 rd_valid");
        check(rd_data, 0, "R1 rd_data");

        // R2 writes with the flag low
        wr(7'd3, 3'b010, 8'h60);
        wr(7'd3, 3'b010, 8'h60);
        check(busy, 0, "R2 no pulse with flag low");
        hv_present = 1'b1;
        @(negedge clk);

        // R3 first 60h only sets up
        wr(7'd3, 3'b010, 8'h60);
        check(busy, 0, "R3 setup starts no pulse");
        wr(7'd3, 3'b010, 8'h40);
        rd(1'b0, "R2 sector 3 untouched");
        wr(7'd0, 3'b010, 8'h40);
        rd(1'b0, "R1 sector 0 clear after reset");

        // R4 R5 protect sector 5
        wr(7'd5, 3'b010, 8'h60);
        follow_pulse(7'd5, -1, -1, -1, 1'b0);
        wr(7'd5, 3'b010, 8'h40);
        rd(1'b1, "R5 sector 5 protected");
        rd(1'b1, "R7 repeat read");
        wr(7'd6, 3'b010, 8'h40);
        rd(1'b0, "R7 sector 6 clear");

        // R6 wrong patterns
        wr(7'd9, 3'b110, 8'h60);
        check(busy, 0, "R6 wrong pattern protect");
        wr(7'd5, 3'b011, 8'h40);
        rd(1'b0, "R6 verify selection kept on sector 6");
        wr(7'd9, 3'b010, 8'h40);
        rd(1'b0, "R6 sector 9 clear");

        // R9 writes while busy
        wr(7'd10, 3'b010, 8'h60);
        follow_pulse(7'd10, -1, 4, -1, 1'b0);
        wr(7'd11, 3'b010, 8'h40);
        rd(1'b0, "R9 sector 11 not protected");
        wr(7'd10, 3'b010, 8'h40);
        rd(1'b1, "R9 sector 10 protected");

        // R8 reissue and boundary sectors
        wr(7'd5, 3'b010, 8'h60);
        follow_pulse(7'd5, -1, -1, -1, 1'b0);
        wr(7'd127, 3'b010, 8'h60);
        follow_pulse(7'd127, -1, -1, -1, 1'b0);
        wr(7'd0, 3'b010, 8'h60);
        follow_pulse(7'd0, -1, -1, -1, 1'b0);
        wr(7'd5, 3'b010, 8'h40);
        rd(1'b1, "R8 sector 5 still protected");
        wr(7'd127, 3'b010, 8'h40);
        rd(1'b1, "R8 sector 127 protected");
        wr(7'd0, 3'b010, 8'h40);
        rd(1'b1, "R8 sector 0 protected");

        // R12 read on the completion cycle
        wr(7'd30, 3'b010, 8'h40);
        wr(7'd30, 3'b010, 8'h60);
        follow_pulse(7'd30, -1, -1, P - 1, 1'b0);
        rd(1'b1, "R12 read after completion");

        // R10 drop mid pulse and on the final cycle
        wr(7'd20, 3'b010, 8'h60);
        follow_pulse(7'd20, 3, -1, -1, 1'b0);
        hv_present = 1'b1;
        @(negedge clk);
        wr(7'd0, 3'b000, 8'h60);
        wr(7'd21, 3'b010, 8'h60);
        follow_pulse(7'd21, P - 1, -1, -1, 1'b0);
        hv_present = 1'b1;
        @(negedge clk);
        wr(7'd0, 3'b000, 8'h60);
        wr(7'd20, 3'b010, 8'h40);
        rd(1'b0, "R10 sector 20 not protected");
        wr(7'd21, 3'b010, 8'h40);
        rd(1'b0, "R10 sector 21 not protected on final-cycle drop");

        // R11 mode ends with the flag
        wr(7'd5, 3'b010, 8'h40);
        rd(1'b1, "R11 pending verify before drop");
        hv_present = 1'b0;
        @(negedge clk);
        hv_present = 1'b1;
        @(negedge clk);
        rd(1'b0, "R11 verify cleared by drop");
        wr(7'd40, 3'b010, 8'h60);
        check(busy, 0, "R11 setup needed again");
        wr(7'd40, 3'b010, 8'h60);
        follow_pulse(7'd40, -1, -1, -1, 1'b0);

        repeat (3) @(negedge clk);
        check(exp_q.size(), 0, "R7 all reads answered");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule